// File: doc/BRIEF.md
# Management PHY Register Model

This block models the management side of an Ethernet PHY as seen from a MAC. A host writes a 32-bit word into a frame register. The block decodes that word as either a read or a write of one 16-bit PHY register. A read puts the register value into the low half of the frame register, where the host can pick it up. A write updates the addressed register through a mask that is specific to that register. Every operation, read or write, sets a done flag. The flag stays set until the host clears it.

The PHY register file holds five registers:

- a control register; restarting autonegotiation through it completes the negotiation at once;
- a status register;
- an advertisement register;
- an interrupt-source register, which is cleared when it is read;
- an interrupt-mask register.

A link-state input stands in for the line side. Each change of this input updates the link and negotiation bits in the status register and sets event bits in the interrupt-source register. Only one PHY address answers. Serial pin timing is not modelled.

Top module: `mgmt_phy_model`

## Requirements
- R1: After reset the registers hold these values: control 0x3000, status 0x7809, advertisement 0x01E1, interrupt source 0x0000, interrupt mask 0x0000. The frame register reads 0 and the done flag is 0.
- R2: A frame-register write is decoded from these fields: bit 29 = 1 is a read and bit 29 = 0 is a write; bits 27:23 are the PHY address; bits 22:18 are the register number; bits 15:0 are the write data.
- R3: On a read, the frame register takes the written word with bits 15:0 replaced by the register value, one clock after the write. On a write, the frame register takes the written word unchanged.
- R4: A write to register 0 stores the data ANDed with 0x7980. If data bit 9 is set, status bit 5 (value 0x0020) is set in the same clock.
- R5: A write to register 4 stores (data AND 0x2D7F) OR 0x0080.
- R6: A write to register 30 (interrupt mask) keeps only data bits 7:0. The upper byte reads as 0.
- R7: A read of register 29 (interrupt source) returns its current value and clears it in the same clock. A link event in that same clock still sets its bits.
- R8: When the link input falls, status bits 5 and 2 (0x0024) clear and interrupt-source bit 4 sets. When it rises, status bits 5 and 2 set and interrupt-source bits 7 and 6 set. The update takes effect one clock after the change.
- R9: Every decoded operation sets the done flag one clock later, whatever the address or register. The flag stays set until the clear input is pulsed. When a set and a clear arrive in the same clock, the set wins.
- R10: These accesses read as 0 and ignore writes: a PHY address other than the configured one (default 0), and any register other than 0, 1, 4, 29 and 30. Registers 1 and 29 are read-only, so writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_wr | input | 1 | Strobe: write frame_wdata into the frame register |
| frame_wdata | input | 32 | Management frame word |
| frame_rdata | output | 32 | Current frame register contents |
| done_clr | input | 1 | Clear strobe for the done flag |
| done_flag | output | 1 | Management operation completed |
| link_up | input | 1 | Line-side link state |

## Verification
The hardest case to reach from the ports is the interrupt-source register. Its bits only appear after link transitions, and each read destroys them. To reach it, the stimulus toggles `link_up` between management reads. It reads register 29 twice each time: once to see the event bits, and once to confirm they were cleared. It also issues a write to register 29 while event bits are pending, then reads the register back to show that the bits survived. The negotiation-complete bit of the status register depends on the history of control writes and link changes. So the tests are run in a fixed order, and the bench carries the expected status value from one test to the next.

// File: rtl/mgmt_phy_pkg.sv
// Package: shared field positions, register numbers, masks and reset
// values of the management PHY model.
// Assumes a 32-bit frame word and 16-bit PHY registers.
package mgmt_phy_pkg;

    localparam int FRAME_W   = 32;
    localparam int PREG_W    = 16;
    localparam int PADDR_W   = 5;
    localparam int REGNO_W   = 5;

    // Frame field positions (the host software decodes these)
    localparam int RD_BIT    = 29;
    localparam int PADDR_LSB = 23;
    localparam int REGNO_LSB = 18;

    // Register numbers
    localparam logic [REGNO_W-1:0] RN_CTRL = 5'd0;
    localparam logic [REGNO_W-1:0] RN_STAT = 5'd1;
    localparam logic [REGNO_W-1:0] RN_ADV  = 5'd4;
    localparam logic [REGNO_W-1:0] RN_ISRC = 5'd29;
    localparam logic [REGNO_W-1:0] RN_IMSK = 5'd30;

    // Reset values and write masks
    localparam logic [PREG_W-1:0] CTRL_RST  = 16'h3000;
    localparam logic [PREG_W-1:0] STAT_RST  = 16'h7809;
    localparam logic [PREG_W-1:0] ADV_RST   = 16'h01E1;
    localparam logic [PREG_W-1:0] CTRL_MASK = 16'h7980;
    localparam logic [PREG_W-1:0] ADV_MASK  = 16'h2D7F;
    localparam logic [PREG_W-1:0] ADV_FORCE = 16'h0080;
    localparam int                AN_RESTART_BIT = 9;
    localparam logic [PREG_W-1:0] STAT_ANDONE = 16'h0020;
    localparam logic [PREG_W-1:0] STAT_LINK   = 16'h0024;

    // Interrupt-source event bits
    localparam logic [7:0] ISRC_UP   = 8'hC0;
    localparam logic [7:0] ISRC_DOWN = 8'h10;

    typedef struct packed {
        logic                is_read;
        logic [PADDR_W-1:0]  paddr;
        logic [REGNO_W-1:0]  regno;
        logic [PREG_W-1:0]   data;
    } mgmt_op_t;

endpackage

// File: rtl/mgmt_frame_decode.sv
// Module: mgmt_frame_decode
// Splits a frame word into its operation fields and qualifies it against
// the configured PHY address. Purely combinational.
// Assumes frame_wr is a single-cycle strobe.
module mgmt_frame_decode
    import mgmt_phy_pkg::*;
#(
    parameter logic [PADDR_W-1:0] PHY_ADDR = '0
) (
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    output mgmt_op_t           op,
    output logic               phy_rd,
    output logic               phy_wr
);

    // Field extraction and address qualification
    always_comb begin
        op.is_read = frame_wdata[RD_BIT];
        op.paddr   = frame_wdata[PADDR_LSB +: PADDR_W];
        op.regno   = frame_wdata[REGNO_LSB +: REGNO_W];
        op.data    = frame_wdata[PREG_W-1:0];
        phy_rd     = frame_wr &&  op.is_read && (op.paddr == PHY_ADDR);
        phy_wr     = frame_wr && !op.is_read && (op.paddr == PHY_ADDR);
    end

endmodule

// File: rtl/phy_regfile.sv
// Module: phy_regfile
// The PHY register set: control, status, advertisement, interrupt source
// (cleared on read) and interrupt mask. It tracks the link input and
// applies link events. Read data is combinational from the register state.
// Assumes phy_rd/phy_wr are already qualified by the PHY address.
module phy_regfile
    import mgmt_phy_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phy_rd,
    input  logic               phy_wr,
    input  logic [REGNO_W-1:0] regno,
    input  logic [PREG_W-1:0]  wdata,
    input  logic               link_up,
    output logic [PREG_W-1:0]  rd_data
);

    logic [PREG_W-1:0] ctrl_q, stat_q, adv_q;
    logic [PREG_W-1:0] ctrl_d, stat_d, adv_d;
    logic [7:0]        isrc_q, isrc_d, imsk_q, imsk_d;
    logic              link_q, evt_up, evt_dn;

    // Link edge detection against the last sampled state
    always_comb begin
        evt_up = link_up && !link_q;
        evt_dn = !link_up && link_q;
    end

    // Next-state for every register; link events are applied after writes
    always_comb begin
        ctrl_d = ctrl_q;
        stat_d = stat_q;
        adv_d  = adv_q;
        imsk_d = imsk_q;
        isrc_d = (phy_rd && regno == RN_ISRC) ? 8'h00 : isrc_q;
        if (phy_wr) begin
            case (regno)
                RN_CTRL: begin
                    ctrl_d = wdata & CTRL_MASK;
                    if (wdata[AN_RESTART_BIT]) stat_d = stat_d | STAT_ANDONE;
                end
                RN_ADV:  adv_d  = (wdata & ADV_MASK) | ADV_FORCE;
                RN_IMSK: imsk_d = wdata[7:0];
                default: ;
            endcase
        end
        if (evt_up) begin
            stat_d = stat_d | STAT_LINK;
            isrc_d = isrc_d | ISRC_UP;
        end
        if (evt_dn) begin
            stat_d = stat_d & ~STAT_LINK;
            isrc_d = isrc_d | ISRC_DOWN;
        end
    end

    // Register state update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            stat_q <= STAT_RST;
            adv_q  <= ADV_RST;
            isrc_q <= '0;
            imsk_q <= '0;
            link_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
            adv_q  <= adv_d;
            isrc_q <= isrc_d;
            imsk_q <= imsk_d;
            link_q <= link_up;
        end
    end

    // Read multiplexer; unimplemented registers read as zero
    always_comb begin
        case (regno)
            RN_CTRL: rd_data = ctrl_q;
            RN_STAT: rd_data = stat_q;
            RN_ADV:  rd_data = adv_q;
            RN_ISRC: rd_data = {8'h00, isrc_q};
            RN_IMSK: rd_data = {8'h00, imsk_q};
            default: rd_data = '0;
        endcase
    end

    // R4: restart request leaves negotiation-complete set
    assert_an_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_wr && regno == RN_CTRL && wdata[AN_RESTART_BIT] && !evt_dn)
        |=> stat_q[5]);

    // R5: advertisement write always leaves bit 7 set
    assert_adv_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_wr && regno == RN_ADV) |=> adv_q[7]);

    // R7: reading interrupt source with no link event leaves it empty
    assert_isrc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rd && regno == RN_ISRC && !evt_up && !evt_dn) |=> isrc_q == 8'h00);

    // R8: link rise sets link bits and event bits
    assert_link_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_up |=> (stat_q[2] && stat_q[5] && isrc_q[7] && isrc_q[6]));

    // R8: link fall clears link bits and sets the down event
    assert_link_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_dn |=> (!stat_q[2] && !stat_q[5] && isrc_q[4]));

endmodule

// File: rtl/mgmt_frame_reg.sv
// Module: mgmt_frame_reg
// Holds the host-visible frame word and the done flag. On a read it merges
// the PHY read data into the low half of the word.
// Assumes phy_data is valid in the same cycle as frame_wr.
module mgmt_frame_reg
    import mgmt_phy_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic [PREG_W-1:0]  phy_data,
    input  logic               done_clr,
    output logic [FRAME_W-1:0] frame_q,
    output logic               done_q
);

    // Frame word capture with read-data merge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (frame_wr) begin
            frame_q <= frame_wdata[RD_BIT]
                     ? {frame_wdata[FRAME_W-1:PREG_W], phy_data}
                     : frame_wdata;
        end
    end

    // Done flag: set by any operation, cleared by the host, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= frame_wr || (done_q && !done_clr);
        end
    end

    // R9: every operation leaves the done flag set
    assert_done_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr |=> done_q);

    // R9: without operation, a clear drops the flag
    assert_done_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !frame_wr) |=> !done_q);

    // R3: the upper half of a read frame keeps the written bits
    assert_frame_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && frame_wdata[RD_BIT])
        |=> frame_q[FRAME_W-1:PREG_W] == $past(frame_wdata[FRAME_W-1:PREG_W]));

endmodule

// File: rtl/mgmt_phy_model.sv
// Module: mgmt_phy_model
// Top level: management frame register, frame decoder and PHY register
// file. A frame write completes in one clock.
// Assumes the host issues at most one frame write per clock.
module mgmt_phy_model
    import mgmt_phy_pkg::*;
#(
    parameter logic [PADDR_W-1:0] PHY_ADDR = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    output logic [FRAME_W-1:0] frame_rdata,
    input  logic               done_clr,
    output logic               done_flag,
    input  logic               link_up
);

    mgmt_op_t          op;
    logic              phy_rd, phy_wr;
    logic [PREG_W-1:0] reg_data, phy_data;

    mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_decode (
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .op          (op),
        .phy_rd      (phy_rd),
        .phy_wr      (phy_wr)
    );

    phy_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .phy_rd  (phy_rd),
        .phy_wr  (phy_wr),
        .regno   (op.regno),
        .wdata   (op.data),
        .link_up (link_up),
        .rd_data (reg_data)
    );

    // Other PHY addresses return zero
    always_comb phy_data = phy_rd ? reg_data : '0;

    mgmt_frame_reg u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .phy_data    (phy_data),
        .done_clr    (done_clr),
        .frame_q     (frame_rdata),
        .done_q      (done_flag)
    );

    // R10: a read of a foreign PHY address returns zero in the low half
    assert_foreign_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && frame_wdata[RD_BIT] && frame_wdata[PADDR_LSB +: PADDR_W] != PHY_ADDR)
        |=> frame_rdata[PREG_W-1:0] == 16'h0000);

endmodule

// File: tb/test_mgmt_phy_model.sv
// Directed bench: one task per scenario, each checking its own results.
module test_mgmt_phy_model;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_wr = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic [31:0] frame_rdata;
    logic        done_clr = 1'b0;
    logic        done_flag;
    logic        link_up = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] exp_stat;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_phy_model i_mgmt_phy_model (
        .clk (clk), .rst_n (rst_n), .frame_wr (frame_wr),
        .frame_wdata (frame_wdata), .frame_rdata (frame_rdata),
        .done_clr (done_clr), .done_flag (done_flag), .link_up (link_up)
    );

    function automatic logic [31:0] mk(input logic rd, input logic [4:0] pa,
                                       input logic [4:0] rn, input logic [15:0] d);
        return {2'b01, rd, ~rd, pa, rn, 2'b10, d};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One frame write; outputs are stable at the following falling edge
    task automatic op(input logic [31:0] w);
        @(negedge clk);
        frame_wr = 1'b1;
        frame_wdata = w;
        @(negedge clk);
        frame_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] pa, input logic [4:0] rn, output logic [15:0] v);
        op(mk(1'b1, pa, rn, 16'h5A5A));
        v = frame_rdata[15:0];
    endtask

    task automatic wr(input logic [4:0] pa, input logic [4:0] rn, input logic [15:0] d);
        op(mk(1'b0, pa, rn, d));
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_up = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1 frame", frame_rdata, 32'h0);
        check("R1 done", {31'b0, done_flag}, 32'h0);
        rd(5'd0, 5'd0, v);  check("R1 ctrl", {16'h0, v}, 32'h3000);
        rd(5'd0, 5'd1, v);  check("R1 status", {16'h0, v}, 32'h7809);
        rd(5'd0, 5'd4, v);  check("R1 adv", {16'h0, v}, 32'h01E1);
        rd(5'd0, 5'd29, v); check("R1 isrc", {16'h0, v}, 32'h0);
        rd(5'd0, 5'd30, v); check("R1 imsk", {16'h0, v}, 32'h0);
        exp_stat = 16'h7809;
    endtask

    task automatic t_frame;
        logic [31:0] w;
        w = {2'b11, 1'b1, 1'b1, 5'd0, 5'd1, 2'b11, 16'hABCD};
        op(w);
        check("R3 read merge", frame_rdata, {w[31:16], exp_stat});
        w = mk(1'b0, 5'd0, 5'd7, 16'h1234);
        op(w);
        check("R3 write frame", frame_rdata, w);
        // R2: bit 29 clear with register 4 fields is a write
        wr(5'd0, 5'd4, 16'h0000);
        op(mk(1'b1, 5'd0, 5'd4, 16'h0));
        check("R2 field decode", {16'h0, frame_rdata[15:0]}, 32'h0080);
    endtask

    task automatic t_done;
        op(mk(1'b1, 5'd0, 5'd0, 16'h0));
        check("R9 set", {31'b0, done_flag}, 32'h1);
        @(negedge clk);
        check("R9 hold", {31'b0, done_flag}, 32'h1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        check("R9 clear", {31'b0, done_flag}, 32'h0);
        @(negedge clk);
        done_clr = 1'b1;
        frame_wr = 1'b1;
        frame_wdata = mk(1'b0, 5'd3, 5'd0, 16'h0);
        @(negedge clk);
        done_clr = 1'b0;
        frame_wr = 1'b0;
        check("R9 set wins", {31'b0, done_flag}, 32'h1);
    endtask

    task automatic t_ctrl_adv_mask;
        logic [15:0] v;
        wr(5'd0, 5'd0, 16'hFFFF);
        rd(5'd0, 5'd0, v); check("R4 ctrl mask", {16'h0, v}, 32'h7980);
        exp_stat = exp_stat | 16'h0020;
        rd(5'd0, 5'd1, v); check("R4 an done", {16'h0, v}, {16'h0, exp_stat});
        wr(5'd0, 5'd4, 16'hFFFF);
        rd(5'd0, 5'd4, v); check("R5 adv ones", {16'h0, v}, 32'h2DFF);
        wr(5'd0, 5'd30, 16'hABCD);
        rd(5'd0, 5'd30, v); check("R6 imsk", {16'h0, v}, 32'h00CD);
    endtask

    task automatic t_link;
        logic [15:0] v;
        set_link(1'b1);
        exp_stat = exp_stat | 16'h0024;
        rd(5'd0, 5'd1, v);  check("R8 up status", {16'h0, v}, {16'h0, exp_stat});
        wr(5'd0, 5'd29, 16'h0000);
        rd(5'd0, 5'd29, v); check("R10 isrc write ignored / R8 up", {16'h0, v}, 32'h00C0);
        rd(5'd0, 5'd29, v); check("R7 clear on read", {16'h0, v}, 32'h0);
        set_link(1'b0);
        exp_stat = exp_stat & ~16'h0024;
        rd(5'd0, 5'd1, v);  check("R8 down status", {16'h0, v}, {16'h0, exp_stat});
        rd(5'd0, 5'd29, v); check("R8 down isrc", {16'h0, v}, 32'h0010);
        rd(5'd0, 5'd29, v); check("R7 clear again", {16'h0, v}, 32'h0);
    endtask

    task automatic t_ignored;
        logic [15:0] v;
        rd(5'd1, 5'd0, v);  check("R10 foreign read", {16'h0, v}, 32'h0);
        wr(5'd1, 5'd0, 16'h0000);
        rd(5'd0, 5'd0, v);  check("R10 foreign write", {16'h0, v}, 32'h7980);
        rd(5'd0, 5'd7, v);  check("R10 unimpl read", {16'h0, v}, 32'h0);
        wr(5'd0, 5'd1, 16'h0000);
        rd(5'd0, 5'd1, v);  check("R10 status ro", {16'h0, v}, {16'h0, exp_stat});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame();
        t_done();
        t_ctrl_adv_mask();
        t_link();
        t_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule